// File: doc/BRIEF.md
# Inbound Doorbell Message Queue

This block takes in short doorbell messages, each made of a 16-bit source identifier, a 16-bit target identifier and a 16-bit info word, and stores them in a circular ring of 8-byte entries. Consumer software finds the oldest unread entry through a dequeue pointer and sees its contents on a head-entry output. When it is done with that entry, it advances the pointer by writing a one-shot increment bit in the mode register. Reading an entry does not move the pointer.

A small register file has four word addresses: status, mode, dequeue pointer and enqueue pointer. Three sticky status flags mark three conditions: the queue holds messages, a message was lost because the ring was full, and a message arrived marked with a transaction error. Software clears each flag by writing a one to its bit. A single interrupt line is the OR of the flags, each gated by its own enable bit in the mode register. One interrupt can cover several pending messages, so the consumer keeps advancing and clearing until the pointers meet.

With the default parameters the ring is 4 KiB long, with 512 slots. One slot always stays free, so at most 511 messages are held at a time. Both byte pointers wrap modulo 4 KiB.

Top module: `doorbell_rx_queue`

## Requirements
- R1: After synchronous reset both pointers read 0, all status flags read 0, the mode register reads 0 and irq is 0.
- R2: An accepted message is stored as the 64-bit entry {16'h0000, target, source, info}, with the pad in bits 63:48 and the info in bits 15:0. head_entry shows the entry at the dequeue pointer one cycle after that pointer or that slot was updated.
- R3: Each accepted message (msg_valid=1, msg_err=0, queue not full) advances the enqueue byte pointer by 8, and the pointer can be read at address 3.
- R4: Writing the mode register (address 1) with bit 0 set advances the dequeue byte pointer by 8; the pointer can be read at address 2. Bit 0 always reads back as 0. The increment is ignored when the queue is empty.
- R5: Status bit 0 (not empty) is set while the pointers differ and stays set until a one is written to it. If the pointers still differ after the clear, it is set again on the following cycle.
- R6: The queue is full when it holds 511 entries. A message that arrives while the queue is full is dropped, leaves the enqueue pointer unchanged and sets status bit 4 (queue full).
- R7: A message that arrives with msg_err=1 is not stored, leaves the enqueue pointer unchanged and sets status bit 7 (transaction error).
- R8: Writing ones to status bits 4 or 7 clears those flags, and writing zeros to them has no effect. A setting event in the same cycle as a clear wins.
- R9: irq is set exactly when some status flag is set and its enable bit is set. Mode bit 1 enables bit 0, mode bit 2 enables bit 4 and mode bit 3 enables bit 7.
- R10: reg_rdata is registered. It shows the register chosen by reg_addr one cycle later: 0 status, 1 mode, 2 dequeue pointer, 3 enqueue pointer.
- R11: Both byte pointers wrap modulo 4096, so a pointer that advances from 4088 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | A doorbell message is present this cycle |
| msg_err | input | 1 | The present message carries a transaction error |
| msg_src | input | 16 | Source identifier |
| msg_tgt | input | 16 | Target identifier |
| msg_info | input | 16 | Info word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| head_entry | output | 64 | Entry at the dequeue pointer |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a ring that is exactly full with both pointers off zero, so that an overflow drop and the pointer wrap come from the same fill. The stimulus first moves both pointers off zero with a few messages and dequeues. It then sends 511 messages back to back so the enqueue pointer wraps to just below the dequeue pointer, offers one more message to force the drop, and drains all 511 entries while a behavioural ring model checks every head entry. Same-cycle races are set up on purpose: a clear write landing on a new error, and a not-empty clear while messages remain.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
  localparam int FIELD_W     = 16;
  localparam int ENTRY_W     = 4 * FIELD_W;
  localparam int ENTRY_SHIFT = 3;

  localparam int ST_NE = 0;
  localparam int ST_QF = 4;
  localparam int ST_TE = 7;

  localparam int MD_INC   = 0;
  localparam int MD_EN_NE = 1;
  localparam int MD_EN_QF = 2;
  localparam int MD_EN_TE = 3;

  typedef enum logic [1:0] {
    RA_STATUS = 2'd0,
    RA_MODE   = 2'd1,
    RA_DEQ    = 2'd2,
    RA_ENQ    = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [FIELD_W-1:0] pad;
    logic [FIELD_W-1:0] tgt;
    logic [FIELD_W-1:0] src;
    logic [FIELD_W-1:0] info;
  } entry_t;
endpackage

// File: rtl/dbq_ring_ram.sv
module dbq_ring_ram #(
  parameter int IDX_W  = 9,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port, old data on a same-address write
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/dbq_ptrs.sv
module dbq_ptrs #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             inc_req,
  output logic [IDX_W-1:0] enq_idx,
  output logic [IDX_W-1:0] deq_idx,
  output logic             empty,
  output logic             full,
  output logic             accept,
  output logic             drop
);
  logic [IDX_W-1:0] enq_q, deq_q;
  logic             adv;

  always_comb begin
    empty  = (enq_q == deq_q);
    full   = ((enq_q + IDX_W'(1)) == deq_q);
    accept = push_req && !full;
    drop   = push_req && full;
    adv    = inc_req && !empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enq_q <= '0;
      deq_q <= '0;
    end else begin
      if (accept) enq_q <= enq_q + IDX_W'(1);
      if (adv)    deq_q <= deq_q + IDX_W'(1);
    end
  end

  assign enq_idx = enq_q;
  assign deq_idx = deq_q;

  // R3: one slot per accepted message
  a_r3_enq_step: assert property (@(posedge clk) disable iff (rst)
    accept |=> (enq_idx == $past(enq_idx) + IDX_W'(1)));

  // R6: a drop leaves the enqueue pointer where it was
  a_r6_drop_holds: assert property (@(posedge clk) disable iff (rst)
    (push_req && full) |=> $stable(enq_idx));

  // R4: increment on an empty ring is ignored
  a_r4_empty_inc_ignored: assert property (@(posedge clk) disable iff (rst)
    (inc_req && empty) |=> $stable(deq_idx));
endmodule

// File: rtl/dbq_csr.sv
module dbq_csr
  import dbq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              ev_nonempty,
  input  logic              ev_drop,
  input  logic              ev_err,
  input  logic [PTR_W-1:0]  deq_ptr,
  input  logic [PTR_W-1:0]  enq_ptr,
  output logic              inc_req,
  output logic              irq,
  output logic [DATA_W-1:0] reg_rdata
);
  logic ne_q, qf_q, te_q;
  logic en_ne_q, en_qf_q, en_te_q;
  logic ne_d, qf_d, te_d;
  logic en_ne_d, en_qf_d, en_te_d;
  logic wr_status, wr_mode;
  logic [7:0] status_v;
  logic [3:0] mode_v;
  logic unused_wdata;

  assign unused_wdata = ^{reg_wdata[DATA_W-1:8], reg_wdata[6:5]};

  always_comb begin
    wr_status = reg_wr && (reg_addr == RA_STATUS);
    wr_mode   = reg_wr && (reg_addr == RA_MODE);
    inc_req   = wr_mode && reg_wdata[MD_INC];

    ne_d = (wr_status && reg_wdata[ST_NE]) ? 1'b0 : (ne_q || ev_nonempty);
    qf_d = ev_drop || (qf_q && !(wr_status && reg_wdata[ST_QF]));
    te_d = ev_err  || (te_q && !(wr_status && reg_wdata[ST_TE]));

    en_ne_d = wr_mode ? reg_wdata[MD_EN_NE] : en_ne_q;
    en_qf_d = wr_mode ? reg_wdata[MD_EN_QF] : en_qf_q;
    en_te_d = wr_mode ? reg_wdata[MD_EN_TE] : en_te_q;

    status_v = {te_q, 2'b00, qf_q, 3'b000, ne_q};
    mode_v   = {en_te_q, en_qf_q, en_ne_q, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ne_q <= 1'b0; qf_q <= 1'b0; te_q <= 1'b0;
      en_ne_q <= 1'b0; en_qf_q <= 1'b0; en_te_q <= 1'b0;
      irq <= 1'b0;
    end else begin
      ne_q <= ne_d; qf_q <= qf_d; te_q <= te_d;
      en_ne_q <= en_ne_d; en_qf_q <= en_qf_d; en_te_q <= en_te_d;
      irq <= (ne_d && en_ne_d) || (qf_d && en_qf_d) || (te_d && en_te_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RA_STATUS: reg_rdata <= DATA_W'(status_v);
        RA_MODE:   reg_rdata <= DATA_W'(mode_v);
        RA_DEQ:    reg_rdata <= DATA_W'(deq_ptr);
        default:   reg_rdata <= DATA_W'(enq_ptr);
      endcase
    end
  end

  // R9: irq only with an enabled flag
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((ne_q && en_ne_q) || (qf_q && en_qf_q) || (te_q && en_te_q)));

  // R7: an erroneous message always leaves the error flag set
  a_r7_err_sets: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> te_q);

  // R8: a drop wins over a simultaneous clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    ev_drop |=> qf_q);

  // R5: not-empty comes back while messages are pending and no clear is written
  a_r5_ne_reasserts: assert property (@(posedge clk) disable iff (rst)
    (ev_nonempty && !(wr_status && reg_wdata[ST_NE])) |=> ne_q);
endmodule

// File: rtl/doorbell_rx_queue.sv
module doorbell_rx_queue
  import dbq_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               msg_valid,
  input  logic               msg_err,
  input  logic [15:0]        msg_src,
  input  logic [15:0]        msg_tgt,
  input  logic [15:0]        msg_info,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [63:0]        head_entry,
  output logic               irq
);
  localparam int PTR_W = IDX_W + ENTRY_SHIFT;

  logic [IDX_W-1:0] enq_idx, deq_idx;
  logic empty, full, accept, drop, inc_req;
  logic push_req;
  entry_t wr_entry;

  assign push_req = msg_valid && !msg_err;

  always_comb begin
    wr_entry.pad  = '0;
    wr_entry.tgt  = msg_tgt;
    wr_entry.src  = msg_src;
    wr_entry.info = msg_info;
  end

  dbq_ptrs #(.IDX_W(IDX_W)) u_ptrs (
    .clk(clk), .rst(rst), .push_req(push_req), .inc_req(inc_req),
    .enq_idx(enq_idx), .deq_idx(deq_idx), .empty(empty), .full(full),
    .accept(accept), .drop(drop)
  );

  dbq_ring_ram #(.IDX_W(IDX_W), .DATA_W(ENTRY_W)) u_ram (
    .clk(clk), .rst(rst), .we(accept), .waddr(enq_idx), .wdata(wr_entry),
    .raddr(deq_idx), .rdata(head_entry)
  );

  dbq_csr #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ev_nonempty(!empty), .ev_drop(drop),
    .ev_err(msg_valid && msg_err),
    .deq_ptr({deq_idx, {ENTRY_SHIFT{1'b0}}}),
    .enq_ptr({enq_idx, {ENTRY_SHIFT{1'b0}}}),
    .inc_req(inc_req), .irq(irq), .reg_rdata(reg_rdata)
  );

  // R6: a full ring never accepts
  a_r6_full_no_write: assert property (@(posedge clk) disable iff (rst)
    (full && msg_valid) |=> $stable(enq_idx));
endmodule

// File: tb/doorbell_rx_queue_tb_top.sv
`timescale 1ns/1ps
module doorbell_rx_queue_tb_top;
  localparam int DATA_W = 32;
  localparam int SLOTS  = 512;
  localparam int RING   = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic msg_valid = 0, msg_err = 0;
  logic [15:0] msg_src = 0, msg_tgt = 0, msg_info = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [DATA_W-1:0] reg_wdata = 0;
  logic [DATA_W-1:0] reg_rdata;
  logic [63:0] head_entry;
  logic irq;

  always #10 clk = ~clk;

  doorbell_rx_queue #(.IDX_W(9), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_err(msg_err),
    .msg_src(msg_src), .msg_tgt(msg_tgt), .msg_info(msg_info),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .head_entry(head_entry), .irq(irq)
  );

  // behavioural model
  int m_enq, m_deq;
  logic [63:0] m_mem [SLOTS];
  bit m_vld [SLOTS];
  bit m_ne, m_qf, m_te, e_ne, e_qf, e_te;
  logic [31:0] e_rdata;
  logic e_irq;
  int nchk = 0, nerr = 0;
  string cur = "R1";

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cycle();
    bit full, empty, wr0, wr1, acc, drop, hv;
    logic [63:0] eh;
    empty = (m_enq == m_deq);
    full  = (((m_enq + 8) % RING) == m_deq);
    acc   = msg_valid && !msg_err && !full;
    drop  = msg_valid && !msg_err && full;
    wr0   = reg_wr && reg_addr == 2'd0;
    wr1   = reg_wr && reg_addr == 2'd1;
    hv    = m_vld[m_deq/8];
    eh    = m_mem[m_deq/8];
    case (reg_addr)
      2'd0: e_rdata = {24'h0, m_te, 2'b00, m_qf, 3'b000, m_ne};
      2'd1: e_rdata = {28'h0, e_te, e_qf, e_ne, 1'b0};
      2'd2: e_rdata = 32'(m_deq);
      default: e_rdata = 32'(m_enq);
    endcase
    m_ne = (wr0 && reg_wdata[0]) ? 1'b0 : (m_ne || !empty);
    m_qf = drop || (m_qf && !(wr0 && reg_wdata[4]));
    m_te = (msg_valid && msg_err) || (m_te && !(wr0 && reg_wdata[7]));
    if (wr1) begin e_ne = reg_wdata[1]; e_qf = reg_wdata[2]; e_te = reg_wdata[3]; end
    e_irq = (m_ne && e_ne) || (m_qf && e_qf) || (m_te && e_te);
    if (acc) begin
      m_mem[m_enq/8] = {16'h0, msg_tgt, msg_src, msg_info};
      m_vld[m_enq/8] = 1;
      m_enq = (m_enq + 8) % RING;
    end
    if (wr1 && reg_wdata[0] && !empty) m_deq = (m_deq + 8) % RING;
    @(posedge clk); #1;
    chk(cur, "reg_rdata", 64'(reg_rdata), 64'(e_rdata));
    chk(cur, "irq", 64'(irq), 64'(e_irq));
    if (hv) chk(cur, "head_entry", head_entry, eh);
  endtask

  task automatic idle();
    msg_valid = 0; msg_err = 0; reg_wr = 0;
    cycle();
  endtask

  task automatic send(input logic [15:0] s, input logic [15:0] t, input logic [15:0] i, input bit e);
    msg_valid = 1; msg_err = e; msg_src = s; msg_tgt = t; msg_info = i; reg_wr = 0;
    cycle();
    msg_valid = 0; msg_err = 0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cycle();
    reg_wr = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] v);
    reg_wr = 0; reg_addr = a;
    cycle();
    v = reg_rdata;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_enq = 0; m_deq = 0; m_ne = 0; m_qf = 0; m_te = 0;
    e_ne = 0; e_qf = 0; e_te = 0;
    for (int k = 0; k < SLOTS; k++) begin m_vld[k] = 0; m_mem[k] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 0;

    cur = "R1";
    rreg(2'd0, v); chk("R1", "status", 64'(v), 0);
    rreg(2'd1, v); chk("R1", "mode", 64'(v), 0);
    rreg(2'd2, v); chk("R1", "deq", 64'(v), 0);
    rreg(2'd3, v); chk("R1", "enq", 64'(v), 0);
    chk("R1", "irq", 64'(irq), 0);

    cur = "R3";
    send(16'h0011, 16'h0022, 16'hA001, 0);
    send(16'h0033, 16'h0044, 16'hA002, 0);
    send(16'h0055, 16'h0066, 16'hA003, 0);
    rreg(2'd3, v); chk("R3", "enq after 3", 64'(v), 24);
    cur = "R2";
    chk("R2", "head first", head_entry, {16'h0, 16'h0022, 16'h0011, 16'hA001});

    cur = "R9";
    chk("R9", "irq disabled", 64'(irq), 0);
    wreg(2'd1, 32'h2);
    chk("R9", "irq ne enabled", 64'(irq), 1);

    cur = "R4";
    wreg(2'd1, 32'h3);
    idle();
    chk("R2", "head second", head_entry, {16'h0, 16'h0044, 16'h0033, 16'hA002});
    rreg(2'd2, v); chk("R4", "deq after inc", 64'(v), 8);
    rreg(2'd1, v); chk("R4", "inc bit reads 0", 64'(v), 2);

    cur = "R5";
    wreg(2'd0, 32'h1);
    rreg(2'd0, v); chk("R5", "ne cleared", 64'(v), 0);
    rreg(2'd0, v); chk("R5", "ne reasserted", 64'(v), 1);

    cur = "R4";
    wreg(2'd1, 32'h3);
    wreg(2'd1, 32'h3);
    wreg(2'd1, 32'h3);
    rreg(2'd2, v); chk("R4", "inc on empty ignored", 64'(v), 24);
    cur = "R5";
    wreg(2'd0, 32'h1);
    idle();
    rreg(2'd0, v); chk("R5", "ne stays clear when empty", 64'(v), 0);

    cur = "R7";
    wreg(2'd1, 32'hE);
    send(16'h0777, 16'h0888, 16'hBEEF, 1);
    rreg(2'd3, v); chk("R7", "enq unchanged on err", 64'(v), 24);
    rreg(2'd0, v); chk("R7", "te set", 64'(v), 32'h80);
    chk("R9", "irq on te", 64'(irq), 1);

    cur = "R8";
    wreg(2'd0, 32'h0);
    rreg(2'd0, v); chk("R8", "zero write no effect", 64'(v), 32'h80);
    msg_valid = 1; msg_err = 1;
    wreg(2'd0, 32'h80);
    msg_valid = 0; msg_err = 0;
    rreg(2'd0, v); chk("R8", "set beats clear", 64'(v), 32'h80);
    wreg(2'd0, 32'h80);
    rreg(2'd0, v); chk("R8", "te cleared", 64'(v), 0);
    chk("R9", "irq low after clear", 64'(irq), 0);

    cur = "R6";
    for (int k = 0; k < 511; k++)
      send(16'(k), 16'(k ^ 16'h5A5A), 16'(k * 3 + 1), 0);
    rreg(2'd3, v); chk("R11", "enq wrapped", 64'(v), 16);
    send(16'hFFFF, 16'hEEEE, 16'hDDDD, 0);
    rreg(2'd3, v); chk("R6", "enq unchanged on drop", 64'(v), 16);
    rreg(2'd0, v); chk("R6", "qf set", 64'(v), 32'h11);
    chk("R9", "irq on qf", 64'(irq), 1);
    wreg(2'd0, 32'h10);
    rreg(2'd0, v); chk("R8", "qf cleared", 64'(v), 32'h01);

    cur = "R11";
    for (int k = 0; k < 511; k++) wreg(2'd1, 32'h1);
    rreg(2'd2, v); chk("R11", "deq wrapped", 64'(v), 16);
    cur = "R10";
    rreg(2'd1, v); chk("R10", "mode readback", 64'(v), 0);
    rreg(2'd3, v); chk("R10", "enq readback", 64'(v), 16);

    summary();
    $finish;
  end
endmodule